// File: doc/BRIEF.md
# Record Slot Map Manager

This block keeps the occupancy table for a store of equal-sized record slots. Each table entry holds a 64-bit record identifier, where the zero value marks a free slot. A count of occupied entries is kept beside the table. The low slots are reserved for a storage header, so every scan begins at a parameterised first usable index. A result index of 0 always means "no slot".

A caller raises `start_i` with an operation code while the block is idle. The block walks the table at one entry per clock and then pulses `done_o` together with a slot index, a status byte and, for enumeration, an identifier. The operations are:

- find an identifier;
- pick the lowest free slot;
- release an identifier;
- walk the occupied entries through a cursor that persists between requests;
- write an entry directly.

The controller has three states. IDLE moves to SCAN when an accepted request needs a table walk. IDLE moves straight to DONE when the result is known without a walk. SCAN moves to DONE when the walk finishes. DONE always returns to IDLE after one cycle.

Top module: `slot_map_mgr`

## Requirements
- R1: After reset the block is idle (`busy_o`=0, `done_o`=0), `rec_count_o` is 0, the result outputs are 0, every slot is free and the walk cursor points at FIRST.
- R2: A start is taken only when `busy_o` is 0. `busy_o` stays high from the cycle after acceptance up to and including the single `done_o` cycle. A start raised while busy has no effect on the table, the count or the results.
- R3: Operation codes on `op_i` are 0 find, 1 pick free, 2 release, 3 walk and 4 direct write. Status codes are 0x00 success, 0x01 no free slot, 0x03 failed and 0x05 not found. Codes 5 to 7 finish with index 0 and status 0x03. `res_id_o` is 0 for every operation except walk.
- R4: Find returns the lowest slot holding `id_i` with status 0x00. It returns index 0 and status 0x05 when the identifier is absent, all zeros or all ones, or when the count is 0.
- R5: The walking operations examine one entry per clock. If E entries are examined, `done_o` is high in the cycle after the (E+1)th rising edge counted from the accepting edge. Requests answered without a walk have E=0.
- R6: Find and release stop walking after the entry at which the number of occupied entries seen reaches the record count.
- R7: Pick free returns the lowest free slot at or above FIRST with status 0x00, or index 0 and status 0x01 when all slots are occupied. It does not change the table.
- R8: Release gives status 0x03 for an all-zeros or all-ones identifier and 0x05 when the identifier is absent. Otherwise it frees the matching entry, decrements the count and returns that slot with status 0x00.
- R9: Walk starts at the cursor. It returns the next occupied slot and its identifier with status 0x00 and leaves the cursor one past that slot.
- R10: When a walk finds nothing, or the count is 0, it returns index 0, identifier all ones and status 0x00, and sets the cursor back to FIRST.
- R11: A walk with `first_i`=1 begins from FIRST regardless of the cursor.
- R12: Direct write stores `id_i` at `idx_i` and returns that index with status 0x00. The count rises by one when a free entry becomes occupied and falls by one when an occupied entry becomes free. An all-ones identifier gives status 0x03 and no change. An index below FIRST or at or above SLOTS is dropped silently: index 0, status 0x00, no change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, taken when idle |
| op_i | input | 3 | Operation code |
| first_i | input | 1 | Walk from the first usable slot |
| id_i | input | IDW | Record identifier argument |
| idx_i | input | IDXW+1 | Slot index for direct write |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| res_idx_o | output | IDXW | Result slot index, 0 for none |
| res_status_o | output | 8 | Result status code |
| res_id_o | output | IDW | Identifier returned by walk |
| rec_count_o | output | IDXW+1 | Number of occupied entries |

## Verification
A wrong record count shows up at once in `rec_count_o` on the `done_o` cycle of the request that changed it. It then shows again as a shifted completion cycle on the next find of an absent identifier, because the early stop depends on that count. A corrupted table entry or cursor stays hidden until the next find, pick-free or walk reaches that slot. The bench therefore checks the latency of every request as well as its index, status and identifier, and it mixes walks among writes and releases so that a stale cursor is exposed within a few requests.

// File: rtl/smm_pkg.sv
package smm_pkg;

    localparam logic [2:0] OP_FIND = 3'd0;
    localparam logic [2:0] OP_TAKE = 3'd1;
    localparam logic [2:0] OP_DROP = 3'd2;
    localparam logic [2:0] OP_WALK = 3'd3;
    localparam logic [2:0] OP_PUT  = 3'd4;

    localparam logic [7:0] STAT_OK   = 8'h00;
    localparam logic [7:0] STAT_FULL = 8'h01;
    localparam logic [7:0] STAT_FAIL = 8'h03;
    localparam logic [7:0] STAT_MISS = 8'h05;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SCAN = 2'd1,
        S_DONE = 2'd2
    } fsm_e;

endpackage

// File: rtl/smm_map_store.sv
module smm_map_store #(
    parameter int SLOTS = 16,
    parameter int FIRST = 2,
    parameter int IDW   = 64,
    localparam int IDXW = $clog2(SLOTS),
    localparam int PW   = IDXW + 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [IDXW-1:0] rd_idx_i,
    output logic [IDW-1:0]  rd_data_o,
    input  logic            wr_en_i,
    input  logic [PW-1:0]   wr_idx_i,
    input  logic [IDW-1:0]  wr_data_i,
    output logic [PW-1:0]   count_o
);
    localparam logic [PW-1:0] SLOTS_P = PW'(SLOTS);
    localparam logic [PW-1:0] FIRST_P = PW'(FIRST);

    logic [IDW-1:0] ent [SLOTS];
    logic           in_range;
    logic [IDW-1:0] old_val;
    logic [PW-1:0]  cnt_q;

    assign in_range = (wr_idx_i >= FIRST_P) && (wr_idx_i < SLOTS_P);

    // Header slots are never stored; usable slots each get a register.
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i < FIRST) begin : g_hdr
            assign ent[i] = '0;
        end else begin : g_use
            logic [IDW-1:0] q;
            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    q <= '0;
                end else if (wr_en_i && in_range && (wr_idx_i == PW'(i))) begin
                    q <= wr_data_i;
                end
            end
            assign ent[i] = q;
        end
    end

    assign rd_data_o = ent[rd_idx_i];
    assign old_val   = in_range ? ent[wr_idx_i[IDXW-1:0]] : '0;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (wr_en_i && in_range) begin
            if ((old_val == '0) && (wr_data_i != '0)) begin
                cnt_q <= cnt_q + PW'(1);
            end else if ((old_val != '0) && (wr_data_i == '0)) begin
                cnt_q <= cnt_q - PW'(1);
            end
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/smm_scan_fsm.sv
module smm_scan_fsm
    import smm_pkg::*;
#(
    parameter int SLOTS = 16,
    parameter int FIRST = 2,
    parameter int IDW   = 64,
    localparam int IDXW = $clog2(SLOTS),
    localparam int PW   = IDXW + 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic [2:0]      op_i,
    input  logic            first_i,
    input  logic [IDW-1:0]  id_i,
    input  logic [PW-1:0]   idx_i,
    input  logic [PW-1:0]   count_i,
    output logic [IDXW-1:0] rd_idx_o,
    input  logic [IDW-1:0]  rd_data_i,
    output logic            wr_en_o,
    output logic [PW-1:0]   wr_idx_o,
    output logic [IDW-1:0]  wr_data_o,
    output logic            busy_o,
    output logic            done_o,
    output logic [IDXW-1:0] res_idx_o,
    output logic [7:0]      res_status_o,
    output logic [IDW-1:0]  res_id_o
);
    localparam logic [PW-1:0]  SLOTS_P = PW'(SLOTS);
    localparam logic [PW-1:0]  FIRST_P = PW'(FIRST);
    localparam logic [PW-1:0]  LAST_P  = PW'(SLOTS - 1);
    localparam logic [IDW-1:0] ID_FREE = '0;
    localparam logic [IDW-1:0] ID_END  = '1;

    fsm_e           st_q, st_d;
    logic [2:0]     op_q;
    logic [IDW-1:0] id_q;
    logic [PW-1:0]  ptr_q;
    logic [PW-1:0]  seen_q;
    logic [PW-1:0]  cur_q;
    logic [IDXW-1:0] res_idx_q;
    logic [7:0]     res_st_q;
    logic [IDW-1:0] res_id_q;

    logic           accept;
    logic           occ, hit, at_last, fin;
    logic [PW-1:0]  seen_nx;
    logic           id_ok, put_ok, put_id_ok, walk_now, find_now;
    logic [PW-1:0]  walk_from;

    assign accept    = (st_q == S_IDLE) && start_i;
    assign rd_idx_o  = ptr_q[IDXW-1:0];
    assign occ       = (rd_data_i != ID_FREE);
    assign hit       = occ && (rd_data_i == id_q);
    assign at_last   = (ptr_q == LAST_P);
    assign seen_nx   = seen_q + PW'(occ);
    assign id_ok     = (id_i != ID_FREE) && (id_i != ID_END);
    assign put_id_ok = (id_i != ID_END);
    assign put_ok    = (idx_i >= FIRST_P) && (idx_i < SLOTS_P);
    assign walk_from = first_i ? FIRST_P : cur_q;
    assign walk_now  = (count_i != '0) && (walk_from < SLOTS_P);
    assign find_now  = id_ok && (count_i != '0);

    // End-of-walk condition per operation, evaluated on the entry under ptr_q.
    always_comb begin
        unique case (op_q)
            OP_FIND, OP_DROP: fin = hit || (seen_nx >= count_i) || at_last;
            OP_TAKE:          fin = !occ || at_last;
            OP_WALK:          fin = occ || at_last;
            default:          fin = 1'b1;
        endcase
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (start_i) begin
                    unique case (op_i)
                        OP_FIND, OP_DROP: st_d = find_now ? S_SCAN : S_DONE;
                        OP_TAKE:          st_d = S_SCAN;
                        OP_WALK:          st_d = walk_now ? S_SCAN : S_DONE;
                        default:          st_d = S_DONE;
                    endcase
                end
            end
            S_SCAN: if (fin) st_d = S_DONE;
            S_DONE: st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= S_IDLE;
        else         st_q <= st_d;
    end

    // Table write requests: direct write at acceptance, release on a hit.
    always_comb begin
        wr_en_o   = 1'b0;
        wr_idx_o  = idx_i;
        wr_data_o = id_i;
        if (accept && (op_i == OP_PUT) && put_id_ok) begin
            wr_en_o = 1'b1;
        end else if ((st_q == S_SCAN) && (op_q == OP_DROP) && hit) begin
            wr_en_o   = 1'b1;
            wr_idx_o  = ptr_q;
            wr_data_o = ID_FREE;
        end
    end

    // Working and result registers.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            op_q      <= OP_FIND;
            id_q      <= '0;
            ptr_q     <= FIRST_P;
            seen_q    <= '0;
            cur_q     <= FIRST_P;
            res_idx_q <= '0;
            res_st_q  <= STAT_OK;
            res_id_q  <= '0;
        end else if (accept) begin
            op_q      <= op_i;
            id_q      <= id_i;
            seen_q    <= '0;
            ptr_q     <= FIRST_P;
            res_idx_q <= '0;
            res_id_q  <= '0;
            unique case (op_i)
                OP_FIND: begin
                    res_st_q <= STAT_MISS;
                end
                OP_DROP: begin
                    res_st_q <= id_ok ? STAT_MISS : STAT_FAIL;
                end
                OP_TAKE: begin
                    res_st_q <= STAT_FULL;
                end
                OP_WALK: begin
                    ptr_q    <= walk_from;
                    res_st_q <= STAT_OK;
                    if (!walk_now) begin
                        res_id_q <= ID_END;
                        cur_q    <= FIRST_P;
                    end
                end
                OP_PUT: begin
                    if (!put_id_ok) begin
                        res_st_q <= STAT_FAIL;
                    end else begin
                        res_st_q <= STAT_OK;
                        if (put_ok) res_idx_q <= idx_i[IDXW-1:0];
                    end
                end
                default: begin
                    res_st_q <= STAT_FAIL;
                end
            endcase
        end else if (st_q == S_SCAN) begin
            ptr_q  <= ptr_q + PW'(1);
            seen_q <= seen_nx;
            unique case (op_q)
                OP_FIND, OP_DROP: begin
                    if (hit) begin
                        res_idx_q <= ptr_q[IDXW-1:0];
                        res_st_q  <= STAT_OK;
                    end
                end
                OP_TAKE: begin
                    if (!occ) begin
                        res_idx_q <= ptr_q[IDXW-1:0];
                        res_st_q  <= STAT_OK;
                    end
                end
                OP_WALK: begin
                    if (occ) begin
                        res_idx_q <= ptr_q[IDXW-1:0];
                        res_id_q  <= rd_data_i;
                        cur_q     <= ptr_q + PW'(1);
                    end else if (at_last) begin
                        res_id_q <= ID_END;
                        cur_q    <= FIRST_P;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy_o       = (st_q != S_IDLE);
    assign done_o       = (st_q == S_DONE);
    assign res_idx_o    = res_idx_q;
    assign res_status_o = res_st_q;
    assign res_id_o     = res_id_q;

endmodule

// File: rtl/slot_map_mgr.sv
module slot_map_mgr #(
    parameter int SLOTS = 16,
    parameter int FIRST = 2,
    parameter int IDW   = 64,
    localparam int IDXW = $clog2(SLOTS),
    localparam int PW   = IDXW + 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic [2:0]      op_i,
    input  logic            first_i,
    input  logic [IDW-1:0]  id_i,
    input  logic [PW-1:0]   idx_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [IDXW-1:0] res_idx_o,
    output logic [7:0]      res_status_o,
    output logic [IDW-1:0]  res_id_o,
    output logic [PW-1:0]   rec_count_o
);
    logic [IDXW-1:0] rd_idx;
    logic [IDW-1:0]  rd_data;
    logic            wr_en;
    logic [PW-1:0]   wr_idx;
    logic [IDW-1:0]  wr_data;
    logic [PW-1:0]   count;

    smm_map_store #(.SLOTS(SLOTS), .FIRST(FIRST), .IDW(IDW)) store_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .count_o   (count)
    );

    smm_scan_fsm #(.SLOTS(SLOTS), .FIRST(FIRST), .IDW(IDW)) fsm_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start_i),
        .op_i         (op_i),
        .first_i      (first_i),
        .id_i         (id_i),
        .idx_i        (idx_i),
        .count_i      (count),
        .rd_idx_o     (rd_idx),
        .rd_data_i    (rd_data),
        .wr_en_o      (wr_en),
        .wr_idx_o     (wr_idx),
        .wr_data_o    (wr_data),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .res_idx_o    (res_idx_o),
        .res_status_o (res_status_o),
        .res_id_o     (res_id_o)
    );

    assign rec_count_o = count;

endmodule

// File: rtl/smm_checker.sv
module smm_checker #(
    parameter int SLOTS = 16,
    parameter int FIRST = 2,
    parameter int IDW   = 64,
    localparam int IDXW = $clog2(SLOTS),
    localparam int PW   = IDXW + 1
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            start_i,
    input logic            busy_o,
    input logic            done_o,
    input logic [IDXW-1:0] res_idx_o,
    input logic [7:0]      res_status_o,
    input logic [IDW-1:0]  res_id_o,
    input logic [PW-1:0]   rec_count_o
);
    a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    a_r2_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i) |=> busy_o);

    a_r2_done_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> busy_o);

    a_r12_count_moves_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rec_count_o != $past(rec_count_o)) |-> done_o);

    a_r12_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ((rec_count_o == $past(rec_count_o)) ||
                    (rec_count_o == $past(rec_count_o) + PW'(1)) ||
                    (rec_count_o == $past(rec_count_o) - PW'(1))));

    a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rec_count_o <= PW'(SLOTS - FIRST));

    a_r3_status_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (res_status_o == 8'h00 || res_status_o == 8'h01 ||
                    res_status_o == 8'h03 || res_status_o == 8'h05));

    a_r4_index_usable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && (res_idx_o != '0)) |-> (res_idx_o >= IDXW'(FIRST)));

    a_r7_full_no_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && (res_status_o == 8'h01)) |-> (res_idx_o == '0));

    a_r10_end_marker: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && (res_idx_o == '0) && (res_id_o != '0)) |-> (res_id_o == '1));

endmodule

bind slot_map_mgr smm_checker #(.SLOTS(SLOTS), .FIRST(FIRST), .IDW(IDW)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .res_idx_o    (res_idx_o),
    .res_status_o (res_status_o),
    .res_id_o     (res_id_o),
    .rec_count_o  (rec_count_o)
);

// File: tb/slot_map_mgr_tb_top.sv
module slot_map_mgr_tb_top;
    localparam int  SLOTS  = 16;
    localparam int  FIRST  = 2;
    localparam int  IDW    = 64;
    localparam int  IDXW   = $clog2(SLOTS);
    localparam int  PW     = IDXW + 1;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [63:0] ONES = '1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [2:0]      op = '0;
    logic            first = 1'b0;
    logic [IDW-1:0]  id = '0;
    logic [PW-1:0]   idx = '0;
    logic            busy, done;
    logic [IDXW-1:0] res_idx;
    logic [7:0]      res_st;
    logic [IDW-1:0]  res_id;
    logic [PW-1:0]   rec_cnt;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [63:0] mdl [SLOTS];
    int mcnt = 0;
    int mcur = FIRST;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    slot_map_mgr #(.SLOTS(SLOTS), .FIRST(FIRST), .IDW(IDW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .first_i(first),
        .id_i(id), .idx_i(idx), .busy_o(busy), .done_o(done), .res_idx_o(res_idx),
        .res_status_o(res_st), .res_id_o(res_id), .rec_count_o(rec_cnt)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Expected result per the requirements, updating the bench model.
    task automatic model(input int o, input bit fst, input logic [63:0] rid, input int wi,
                         output int e_idx, output int e_st, output logic [63:0] e_id,
                         output int e_lat);
        int e = 0;
        int seen = 0;
        int from;
        bit got = 0;
        e_idx = 0; e_st = 0; e_id = '0;
        case (o)
            0, 2: begin
                if (o == 2 && (rid == 0 || rid == ONES)) e_st = 3;
                else if (rid == 0 || rid == ONES || mcnt == 0) e_st = 5;
                else begin
                    e_st = 5;
                    for (int i = FIRST; i < SLOTS; i++) begin
                        e++;
                        if (mdl[i] == rid) begin e_idx = i; e_st = 0; break; end
                        if (mdl[i] != 0) seen++;
                        if (seen >= mcnt) break;
                    end
                    if (o == 2 && e_idx != 0) begin mdl[e_idx] = 0; mcnt--; end
                end
            end
            1: begin
                e_st = 1;
                for (int i = FIRST; i < SLOTS; i++) begin
                    e++;
                    if (mdl[i] == 0) begin e_idx = i; e_st = 0; break; end
                end
            end
            3: begin
                from = fst ? FIRST : mcur;
                e_id = ONES;
                if (mcnt != 0 && from < SLOTS) begin
                    for (int i = from; i < SLOTS; i++) begin
                        e++;
                        if (mdl[i] != 0) begin
                            e_idx = i; e_id = mdl[i]; mcur = i + 1; got = 1; break;
                        end
                    end
                end
                if (!got) mcur = FIRST;
            end
            4: begin
                if (rid == ONES) e_st = 3;
                else if (wi >= FIRST && wi < SLOTS) begin
                    e_idx = wi;
                    if (mdl[wi] == 0 && rid != 0) mcnt++;
                    if (mdl[wi] != 0 && rid == 0) mcnt--;
                    mdl[wi] = rid;
                end
            end
            default: e_st = 3;
        endcase
        e_lat = e + 1;
    endtask

    task automatic do_op(input int o, input bit fst, input logic [63:0] rid, input int wi,
                         input string tag);
        int e_idx, e_st, e_lat;
        logic [63:0] e_id;
        int lat = 0;
        model(o, fst, rid, wi, e_idx, e_st, e_id, e_lat);
        @(negedge clk);
        start = 1'b1; op = 3'(o); first = fst; id = rid; idx = PW'(wi);
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 100) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        chk(done == 1'b1, tag, "done seen", 64'(done), 64'd1);
        chk(lat == e_lat, tag, "R5 latency", 64'(lat), 64'(e_lat));
        chk(int'(res_idx) == e_idx, tag, "index", 64'(res_idx), 64'(e_idx));
        chk(int'(res_st) == e_st, tag, "status", 64'(res_st), 64'(e_st));
        chk(res_id == e_id, tag, "identifier", res_id, e_id);
        chk(int'(rec_cnt) == mcnt, tag, "count", 64'(rec_cnt), 64'(mcnt));
    endtask

    function automatic string tag_of(input int o);
        case (o)
            0: return "R4";
            1: return "R7";
            2: return "R8";
            3: return "R9";
            4: return "R12";
            default: return "R3";
        endcase
    endfunction

    initial begin
        for (int i = 0; i < SLOTS; i++) mdl[i] = '0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0 && done == 1'b0, "R1", "idle after reset", 64'({busy, done}), 64'd0);
        chk(rec_cnt == '0, "R1", "count after reset", 64'(rec_cnt), 64'd0);
        chk(res_idx == '0 && res_id == '0, "R1", "results after reset", res_id, 64'd0);
        do_op(1, 0, 0, 0, "R1");                 // all slots free: FIRST comes back
        do_op(3, 0, 0, 0, "R10");                // walk on empty store
        do_op(0, 0, 64'h11, 0, "R4");            // find with count 0
        // R12: direct writes, dropped indices, rejected all-ones
        do_op(4, 0, 64'h11, 2, "R12");
        do_op(4, 0, 64'h22, 3, "R12");
        do_op(4, 0, 64'h33, 0, "R12");           // below FIRST: dropped
        do_op(4, 0, 64'h33, SLOTS, "R12");       // beyond table: dropped
        do_op(4, 0, ONES, 4, "R12");             // all-ones rejected
        // R6: absent identifier stops after the second occupied entry
        do_op(0, 0, 64'h99, 0, "R6");
        do_op(2, 0, 64'h99, 0, "R6");
        do_op(0, 0, 64'h22, 0, "R4");
        do_op(0, 0, 64'h0, 0, "R4");
        do_op(0, 0, ONES, 0, "R4");
        // R8: release corner cases
        do_op(2, 0, 64'h0, 0, "R8");
        do_op(2, 0, ONES, 0, "R8");
        do_op(2, 0, 64'h11, 0, "R8");
        do_op(1, 0, 0, 0, "R7");                 // freed slot is lowest again
        // R9, R10, R11: walk sequence with wrap
        do_op(4, 0, 64'h44, 9, "R9");
        do_op(4, 0, 64'h55, SLOTS - 1, "R9");
        do_op(3, 1, 0, 0, "R11");
        do_op(3, 0, 0, 0, "R9");
        do_op(3, 0, 0, 0, "R9");
        do_op(3, 0, 0, 0, "R10");                // cursor past last slot
        do_op(3, 0, 0, 0, "R9");                 // restarted from FIRST
        do_op(3, 1, 0, 0, "R11");
        do_op(6, 0, 0, 0, "R3");
        // R7: fill every slot, then no free slot
        for (int i = FIRST; i < SLOTS; i++) do_op(4, 0, 64'(100 + i), i, "R7");
        do_op(1, 0, 0, 0, "R7");
        do_op(0, 0, 64'(100 + SLOTS - 1), 0, "R4");
        // R2: start raised while busy must not write
        @(negedge clk);
        start = 1'b1; op = 3'd1; first = 1'b0; id = '0; idx = '0;
        @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b1, "R2", "busy after accept", 64'(busy), 64'd1);
        op = 3'd4; id = 64'h0; idx = PW'(FIRST);    // would free a slot if taken
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        while (!done) begin @(posedge clk); @(negedge clk); end
        chk(res_st == 8'h01, "R2", "first request still reported", 64'(res_st), 64'h01);
        @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R2", "idle after done", 64'({busy, done}), 64'd0);
        chk(int'(rec_cnt) == mcnt, "R2", "ignored start left count", 64'(rec_cnt), 64'(mcnt));
        do_op(0, 0, 64'(100 + FIRST), 0, "R2");
        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            int o, wi, sel;
            logic [63:0] rid;
            sel = int'($urandom_range(0, 99));
            o = (sel < 30) ? 4 : (sel < 45) ? 0 : (sel < 55) ? 1 : (sel < 75) ? 2 :
                (sel < 97) ? 3 : 5 + int'($urandom_range(0, 2));
            rid = 64'($urandom_range(1, 8));
            if ($urandom_range(0, 19) == 0) rid = 0;
            if ($urandom_range(0, 29) == 0) rid = ONES;
            wi = int'($urandom_range(0, SLOTS + 1));
            do_op(o, $urandom_range(0, 5) == 0, rid, wi, tag_of(o));
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule